// File: doc/BRIEF.md
# Programmable Up-Counting Time Base

This block is a general-purpose time base. A prescale stage divides the clock by a programmable amount and produces a count tick. An up-counter advances on each tick from zero up to a programmable reload limit. On the tick that would carry the counter past the limit, the counter returns to zero and an update event fires. The update event sets a sticky interrupt flag. The flag drives an interrupt request when its enable bit is set.

Software programs the block through a plain synchronous register port. A write happens on the rising clock edge when `wr_en` is high. Read data is a combinational function of `addr`. Both the divider and the reload limit are stored as "N-1" values: a divider of D gives D+1 clocks per tick, and a limit of L gives L+1 ticks per period.

The reload limit has a shadow copy. When buffering is off, a reload write changes the running limit at once. When buffering is on, the write is parked and only taken over at the next update event. The divider always runs from its shadow, which is loaded only by an update event. Software can force an update through a command bit that reads back as zero. Two control bits decide whether a forced update raises the flag, and whether updates happen at all.

Register map (address: contents):
- 0: control. bit0 = run, bit1 = hold updates, bit2 = flag on overflow only, bit3 = buffered reload, bit4 = interrupt enable.
- 1: status. bit0 = update flag.
- 2: command. bit0 = force update.
- 3: counter value.
- 4: divider.
- 5: reload limit.

Top module: `tmr_basetop`

## Requirements
- R1: After reset, every register reads zero, and `irq_o` and `upd_o` are low.
- R2: While control bit0 (run) is 1, the counter advances once every divider+1 clocks. While run is 0, the counter holds its value.
- R3: Ticks take the counter from 0 up to the active reload limit. The next tick returns it to 0, and `upd_o` is high in the cycle of that tick. If updates are not held, that tick also sets status bit0.
- R4: With control bit3 (buffered reload) at 0, a write to address 5 changes the active limit from the next clock on.
- R5: With control bit3 at 1, a write to address 5 reads back at once. The counter keeps using the old limit until the next update event, which copies the new value across.
- R6: A write to address 4 reads back at once but changes the tick rate only after the next update event.
- R7: Writing 1 to bit0 of address 2 zeroes the counter and the prescale count, and loads both shadows. It sets status bit0 unless control bit1 or bit2 is 1. Address 2 always reads 0.
- R8: With control bit2 (flag on overflow only) at 1, a forced update still loads the shadows but leaves status bit0 clear. A counter wrap still sets status bit0.
- R9: With control bit1 (hold updates) at 1, no update event occurs. A wrap leaves status bit0 clear and leaves the shadows unloaded, but the counter still returns to 0 at the limit. A forced update only zeroes the counter.
- R10: If, with buffering off, the limit is written below the current count, no update occurs until the counter has rolled over at its full width and then reached the new limit.
- R11: Status bit0 clears only when software writes 0 to bit0 of address 1. Writing 1 there has no effect. `irq_o` equals status bit0 ANDed with control bit4.
- R12: A write to address 3 loads the counter with the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 3 | Register address, used for both reads and writes |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `addr`, zero-extended |
| upd_o | output | 1 | High in the cycle whose edge performs an update event |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties assume the following about the inputs:
- At most one register access happens per cycle, because the port is a single shared bus. A counter write and a forced update therefore never coincide.
- Unmapped addresses are never written.
- All properties are armed only after a synchronous reset.

The stimulus respects these assumptions. It changes inputs only on the falling clock edge, issues one write per cycle through a single task, and touches only the six mapped addresses. The divider values it programs keep the prescale count inside the bound that the prescaler property checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_CMD    = 3'd2,
    A_CNT    = 3'd3,
    A_DIV    = 3'd4,
    A_RELOAD = 3'd5
  } tmr_addr_e;

  // Field order fixes the bit positions: run is bit0, irq_en is bit4.
  typedef struct packed {
    logic irq_en;
    logic buffered;
    logic ovf_only;
    logic hold_upd;
    logic run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          load,
  input  logic [PW-1:0] div_pre,
  output logic          tick
);

  logic [PW-1:0] div_act;
  logic [PW-1:0] ps_cnt;

  assign tick = run && (ps_cnt == div_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_cnt  <= '0;
      div_act <= '0;
    end else begin
      if (restart)   ps_cnt <= '0;
      else if (run)  ps_cnt <= tick ? '0 : ps_cnt + 1'b1;
      if (load)      div_act <= div_pre;
    end
  end

  AST_PS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ps_cnt <= div_act); // R2
  AST_PS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(ps_cnt)); // R2

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          lim_direct,
  input  logic [CW-1:0] lim_wdata,
  input  logic          load,
  input  logic [CW-1:0] lim_pre,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim_act,
  output logic          wrap
);

  logic at_lim;

  assign at_lim = (cnt == lim_act);
  assign wrap   = tick && at_lim && !restart && !cnt_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (tick) begin
      cnt <= at_lim ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          lim_act <= '0;
    else if (lim_direct) lim_act <= lim_wdata;
    else if (load)       lim_act <= lim_pre;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !cnt_wr && !at_lim) |=> cnt == CW'($past(cnt) + 1'b1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !cnt_wr) |=> $stable(cnt)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !restart) |=> cnt == $past(cnt_wdata)); // R12

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              flag_set,
  input  logic [CW-1:0]     cnt,
  output tmr_ctrl_t         ctrl,
  output logic [PW-1:0]     div_pre,
  output logic [CW-1:0]     lim_pre,
  output logic              flag,
  output logic              cnt_wr,
  output logic              lim_wr,
  output logic              force_req,
  output logic [DW-1:0]     rd_data
);

  logic wr_ctrl, wr_stat, wr_div, flag_clr;
  logic unused_wdata;

  assign unused_wdata = ^wr_data;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_stat   = wr_en && (addr == A_STAT);
  assign wr_div    = wr_en && (addr == A_DIV);
  assign cnt_wr    = wr_en && (addr == A_CNT);
  assign lim_wr    = wr_en && (addr == A_RELOAD);
  assign force_req = wr_en && (addr == A_CMD) && wr_data[0];
  assign flag_clr  = wr_stat && !wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      div_pre <= '0;
      lim_pre <= '0;
      flag    <= 1'b0;
    end else begin
      if (wr_ctrl)       ctrl    <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_div)        div_pre <= wr_data[PW-1:0];
      if (lim_wr)        lim_pre <= wr_data[CW-1:0];
      if (flag_set)      flag    <= 1'b1;
      else if (flag_clr) flag    <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:   rd_data = DW'(ctrl);
      A_STAT:   rd_data = DW'(flag);
      A_CNT:    rd_data = DW'(cnt);
      A_DIV:    rd_data = DW'(div_pre);
      A_RELOAD: rd_data = DW'(lim_pre);
      default:  rd_data = '0;
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !flag); // R11

endmodule

// File: rtl/tmr_basetop.sv
module tmr_basetop
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              upd_o,
  output logic              irq_o
);

  tmr_ctrl_t     ctrl;
  logic [PW-1:0] div_pre;
  logic [CW-1:0] lim_pre, lim_act, cnt;
  logic          flag, cnt_wr, lim_wr, force_req;
  logic          tick, wrap, upd, flag_set, lim_direct;

  assign upd        = !ctrl.hold_upd && (force_req || wrap);
  assign flag_set   = !ctrl.hold_upd && (wrap || (force_req && !ctrl.ovf_only));
  assign lim_direct = lim_wr && !ctrl.buffered;
  assign upd_o      = upd;
  assign irq_o      = flag && ctrl.irq_en;

  tmr_regs #(.DW(DW), .CW(CW), .PW(PW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .flag_set  (flag_set),
    .cnt       (cnt),
    .ctrl      (ctrl),
    .div_pre   (div_pre),
    .lim_pre   (lim_pre),
    .flag      (flag),
    .cnt_wr    (cnt_wr),
    .lim_wr    (lim_wr),
    .force_req (force_req),
    .rd_data   (rd_data)
  );

  tmr_prescaler #(.PW(PW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .restart (force_req),
    .load    (upd),
    .div_pre (div_pre),
    .tick    (tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .restart    (force_req),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (wr_data[CW-1:0]),
    .lim_direct (lim_direct),
    .lim_wdata  (wr_data[CW-1:0]),
    .load       (upd),
    .lim_pre    (lim_pre),
    .cnt        (cnt),
    .lim_act    (lim_act),
    .wrap       (wrap)
  );

  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    force_req |=> cnt == '0); // R7
  AST_LIM_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.buffered && !upd) |=> $stable(lim_act)); // R5
  AST_LIM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    lim_direct |=> lim_act == $past(wr_data[CW-1:0])); // R4
  AST_HOLD_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.hold_upd && !flag) |=> !flag); // R9
  AST_OVF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ovf_only && !wrap && !flag) |=> !flag); // R8

endmodule

// File: tb/sim_tmr_basetop.sv
module sim_tmr_basetop;
  import tmr_pkg::*;

  localparam int DW = 32;
  localparam logic [1:0] OP_WR = 2'd0, OP_IDLE = 2'd1, OP_RD = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          upd_o, irq_o;

  int applied = 0;
  int miscmp = 0;

  always #4 clk = ~clk;

  tmr_basetop #(.DW(DW), .CW(16), .PW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .upd_o(upd_o), .irq_o(irq_o)
  );

  // vector: op | addr | data (write value or idle cycles) | expected | requirement
  function automatic logic [56:0] v(input logic [1:0] op, input logic [2:0] a,
                                    input logic [31:0] d, input logic [15:0] e,
                                    input logic [3:0] r);
    return {op, a, d, e, r};
  endfunction

  localparam logic [56:0] VECS [0:63] = '{
    v(OP_WR, 5, 4, 0, 4), v(OP_WR, 0, 'h11, 0, 2), v(OP_IDLE, 0, 3, 0, 2),
    v(OP_RD, 3, 0, 3, 2),                                   // R2 one tick per clock
    v(OP_IDLE, 0, 2, 0, 3), v(OP_RD, 1, 0, 1, 3),           // R3 wrap sets flag
    v(OP_WR, 1, 0, 0, 11), v(OP_WR, 1, 1, 0, 11),
    v(OP_RD, 1, 0, 0, 11),                                  // R11 clear by 0, 1 ignored
    v(OP_WR, 0, 'h19, 0, 5), v(OP_WR, 5, 9, 0, 5),
    v(OP_RD, 5, 0, 9, 5), v(OP_RD, 3, 0, 4, 5),             // R5 parked value reads back
    v(OP_IDLE, 0, 1, 0, 5), v(OP_RD, 3, 0, 0, 5),           // R5 old limit still used
    v(OP_IDLE, 0, 9, 0, 5), v(OP_RD, 3, 0, 9, 5),
    v(OP_IDLE, 0, 1, 0, 5), v(OP_RD, 3, 0, 0, 5),           // R5 new limit after update
    v(OP_WR, 0, 'h11, 0, 6), v(OP_WR, 1, 0, 0, 6), v(OP_WR, 4, 1, 0, 6),
    v(OP_IDLE, 0, 2, 0, 6), v(OP_RD, 3, 0, 5, 6),           // R6 divider not yet live
    v(OP_WR, 2, 1, 0, 7), v(OP_RD, 3, 0, 0, 7),             // R7 force zeroes
    v(OP_RD, 1, 0, 1, 7),                                   // R7 force sets flag
    v(OP_IDLE, 0, 2, 0, 6), v(OP_RD, 3, 0, 1, 6),           // R6 divide by two now
    v(OP_IDLE, 0, 2, 0, 6), v(OP_RD, 3, 0, 2, 6),
    v(OP_WR, 1, 0, 0, 8), v(OP_WR, 0, 'h15, 0, 8), v(OP_WR, 4, 0, 0, 8),
    v(OP_WR, 2, 1, 0, 8), v(OP_RD, 1, 0, 0, 8),             // R8 force leaves flag clear
    v(OP_IDLE, 0, 3, 0, 8), v(OP_RD, 3, 0, 3, 8),           // R8 divider still reloaded
    v(OP_IDLE, 0, 7, 0, 8), v(OP_RD, 1, 0, 1, 8),           // R8 overflow still flags
    v(OP_WR, 1, 0, 0, 9), v(OP_WR, 0, 'h1B, 0, 9), v(OP_WR, 5, 3, 0, 9),
    v(OP_IDLE, 0, 6, 0, 9), v(OP_IDLE, 0, 1, 0, 9),
    v(OP_RD, 1, 0, 0, 9),                                   // R9 wrap without flag
    v(OP_IDLE, 0, 9, 0, 9), v(OP_RD, 3, 0, 9, 9),           // R9 shadow not loaded
    v(OP_WR, 2, 1, 0, 9), v(OP_RD, 3, 0, 0, 9),             // R9 force only zeroes
    v(OP_IDLE, 0, 4, 0, 9), v(OP_RD, 3, 0, 4, 9),
    v(OP_WR, 0, 'h11, 0, 10), v(OP_WR, 5, 2, 0, 10),
    v(OP_IDLE, 0, 1, 0, 10), v(OP_RD, 3, 0, 7, 10),         // R10 limit now below count
    v(OP_IDLE, 0, 65528, 0, 10), v(OP_RD, 3, 0, 65535, 10),
    v(OP_IDLE, 0, 1, 0, 10), v(OP_RD, 1, 0, 0, 10),         // R10 rollover is no update
    v(OP_IDLE, 0, 2, 0, 4), v(OP_RD, 3, 0, 2, 4),           // R4 direct limit in force
    v(OP_IDLE, 0, 1, 0, 10), v(OP_RD, 1, 0, 1, 10)          // R10 update at new limit
  };

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [DW-1:0] exp, input int rq);
    wr_en = 1'b0; addr = a;
    #1;
    applied++;
    if (rd_data !== exp) begin
      miscmp++;
      $display("FAIL R%0d addr %0d: got %0h expected %0h", rq, a, rd_data, exp);
    end
  endtask

  task automatic pin_chk(input logic got, input logic exp, input int rq);
    #1;
    applied++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL R%0d pin: got %0b expected %0b", rq, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscmp++;
    $display("FAIL R0 watchdog expired: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    do_reset();
    for (int a = 0; a < 6; a++) rd_chk(3'(a), '0, 1);      // R1 reset values
    pin_chk(irq_o, 1'b0, 1);                               // R1
    pin_chk(upd_o, 1'b0, 1);                               // R1

    for (int i = 0; i < 64; i++) begin
      case (VECS[i][56:55])
        OP_WR:   wr(VECS[i][54:52], VECS[i][51:20]);
        OP_IDLE: idle(int'(VECS[i][51:20]));
        default: rd_chk(VECS[i][54:52], DW'(VECS[i][19:4]), int'(VECS[i][3:0]));
      endcase
    end

    // R12 counter load and R2 hold while stopped
    wr(A_CTRL, 'h10);
    wr(A_CNT, 7);
    rd_chk(A_CNT, 7, 12);                                  // R12
    idle(3);
    rd_chk(A_CNT, 7, 2);                                   // R2
    rd_chk(A_CMD, 0, 7);                                   // R7 command reads zero

    // R3 update pulse, R11 interrupt gating, from a fresh reset
    do_reset();
    wr(A_RELOAD, 1);
    wr(A_CTRL, 'h01);
    idle(1);
    pin_chk(upd_o, 1'b1, 3);                               // R3 wrap cycle
    idle(1);
    pin_chk(upd_o, 1'b0, 3);
    rd_chk(A_STAT, 1, 3);
    pin_chk(irq_o, 1'b0, 11);                              // R11 masked
    wr(A_CTRL, 'h11);
    pin_chk(irq_o, 1'b1, 11);                              // R11 enabled
    wr(A_CTRL, 'h10);
    wr(A_STAT, 0);
    pin_chk(irq_o, 1'b0, 11);                              // R11 cleared

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule